// File: doc/BRIEF.md
# Configuration Store with Security Lock

This block is the configuration memory controller of a programmable logic cell. It holds the fuse pattern for the product-term array, one packed word of per-macrocell mode bits, a security bit and a signature register. It drives the stored pattern and mode bits straight to the logic it configures. A simple command port (valid, opcode, address, write data, seal flag) carries six operations: bulk erase, program, verify read, lock, signature write and signature read. Each command is taken in one cycle. Exactly one cycle later the block raises a completion pulse or a refusal pulse.

Storage behaves like erasable non-volatile cells. An erased bit reads 1, meaning the connection is open. Programming can only clear bits, so rewriting a location with new content first needs a bulk erase. Setting the security bit blocks readback of the pattern and blocks any further change to it. Only a bulk erase releases the lock. The signature stays readable while the lock is set, so a locked part can still report which design revision it carries.

Top module: `cfg_store_lock`

## Requirements
- R1: After reset, every fuse bit and every mode bit is 1, the signature is 0, `sec_locked` is 0, and `rsp_done`, `rsp_err` and `rsp_rdata` are 0.
- R2: Erase (opcode 1) is accepted even while locked. It sets every fuse and mode bit to 1, clears the signature to 0 and clears the security bit.
- R3: Program (opcode 2) at address a < ROWS replaces fuse row a with `old & cmd_wdata`. At address ROWS it does the same to the mode word, using the low MACROCELLS*MODE_W data bits. Bits that are already 0 stay 0.
- R4: Verify (opcode 3) returns the addressed fuse row, or the mode word zero-extended, on `rsp_rdata` together with `rsp_done`.
- R5: Lock (opcode 4) sets `sec_locked`, and the lock holds until the next erase.
- R6: A program command accepted with `cmd_seal`=1 stores its data and sets `sec_locked` in the same cycle.
- R7: While locked, program, verify and signature write are refused. Stored fuses, modes and signature stay unchanged, and `rsp_rdata` is 0.
- R8: Signature read (opcode 6) returns the addressed signature word whether or not the lock is set.
- R9: Signature write (opcode 5) stores word a of the SIG_W-bit signature (SIG_W is 24 or 64), which is split into DATA_W-bit words with word 0 lowest. Bits beyond SIG_W read back as 0.
- R10: A program or verify at an address above ROWS, and a signature access at an address at or above ceil(SIG_W/DATA_W), are refused.
- R11: Every cycle with `cmd_valid` high is followed one cycle later by exactly one of `rsp_done` or `rsp_err`, and a cycle without a command is followed by neither. Opcodes 0 and 7 are refused.
- R12: `rsp_rdata` is 0 in every cycle that does not complete a verify or signature read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Opcode: 1 erase, 2 program, 3 verify, 4 lock, 5 signature write, 6 signature read |
| cmd_addr | input | ADDR_W | Fuse row, mode word (ROWS) or signature word index |
| cmd_wdata | input | DATA_W | Program or signature data |
| cmd_seal | input | 1 | With program: set the lock after storing |
| rsp_done | output | 1 | Command completed (one-cycle pulse) |
| rsp_err | output | 1 | Command refused (one-cycle pulse) |
| rsp_rdata | output | DATA_W | Read result, valid with `rsp_done` |
| sec_locked | output | 1 | Security bit |
| cfg_fuses | output | ROWS*DATA_W | Stored fuse pattern, row 0 in the low bits |
| cfg_modes | output | MACROCELLS*MODE_W | Stored macrocell mode bits |

## Verification
The bench builds the block with four fuse rows of 16 bits, five macrocells with two mode bits each and a 24-bit signature. This makes the mode word a 10-bit field inside a 16-bit data word and splits the signature into a full word and an 8-bit partial word, so the masking of the partial word can be seen at the port. With an address width of 4, the out-of-range addresses just past the mode word and just past the last signature word are reachable. The sequences program without an erase, lock by both routes, try every refused command while locked, and then unlock with an erase.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_ERASE  = 3'd1,
      OP_PROG   = 3'd2,
      OP_VERIFY = 3'd3,
      OP_LOCK   = 3'd4,
      OP_SIG_WR = 3'd5,
      OP_SIG_RD = 3'd6,
      OP_RSVD   = 3'd7
   } cfg_op_e;

   typedef struct packed {
      logic accept;
      logic refuse;
      logic erase;
      logic fuse_we;
      logic mode_we;
      logic sig_we;
      logic set_lock;
      logic rd_fuse;
      logic rd_mode;
      logic rd_sig;
   } cfg_ctl_t;

endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
   import cfg_store_pkg::*;
#(
   parameter int ROWS      = 8,
   parameter int SIG_WORDS = 2,
   parameter int ADDR_W    = 4
) (
   input  logic              valid,
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic              seal,
   input  logic              locked,
   output cfg_ctl_t          ctl
);

   localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(ROWS);
   localparam logic [ADDR_W-1:0] SIG_LIM   = ADDR_W'(SIG_WORDS);

   logic fuse_hit, mode_hit, sig_hit;

   assign fuse_hit = addr < MODE_ADDR;
   assign mode_hit = addr == MODE_ADDR;
   assign sig_hit  = addr < SIG_LIM;

   always_comb begin
      ctl = '0;
      if (valid) begin
         case (cfg_op_e'(op))
            OP_ERASE: begin
               ctl.accept = 1'b1;
               ctl.erase  = 1'b1;
            end
            OP_PROG: begin
               if (!locked && (fuse_hit || mode_hit)) begin
                  ctl.accept   = 1'b1;
                  ctl.fuse_we  = fuse_hit;
                  ctl.mode_we  = mode_hit;
                  ctl.set_lock = seal;
               end else begin
                  ctl.refuse = 1'b1;
               end
            end
            OP_VERIFY: begin
               if (!locked && (fuse_hit || mode_hit)) begin
                  ctl.accept  = 1'b1;
                  ctl.rd_fuse = fuse_hit;
                  ctl.rd_mode = mode_hit;
               end else begin
                  ctl.refuse = 1'b1;
               end
            end
            OP_LOCK: begin
               ctl.accept   = 1'b1;
               ctl.set_lock = 1'b1;
            end
            OP_SIG_WR: begin
               if (!locked && sig_hit) begin
                  ctl.accept = 1'b1;
                  ctl.sig_we = 1'b1;
               end else begin
                  ctl.refuse = 1'b1;
               end
            end
            OP_SIG_RD: begin
               if (sig_hit) begin
                  ctl.accept = 1'b1;
                  ctl.rd_sig = 1'b1;
               end else begin
                  ctl.refuse = 1'b1;
               end
            end
            default: ctl.refuse = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/cfg_fuse_bank.sv
module cfg_fuse_bank #(
   parameter int ROWS      = 8,
   parameter int DATA_W    = 16,
   parameter int MODE_BITS = 8,
   parameter int ADDR_W    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   erase,
   input  logic                   fuse_we,
   input  logic                   mode_we,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [ROWS*DATA_W-1:0] fuses,
   output logic [MODE_BITS-1:0]   modes,
   output logic [DATA_W-1:0]      rd_fuse,
   output logic [DATA_W-1:0]      rd_mode
);

   logic [DATA_W-1:0] row_q [ROWS];

   for (genvar g = 0; g < ROWS; g++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            row_q[g] <= '1;
         else if (erase)
            row_q[g] <= '1;
         else if (fuse_we && addr == ADDR_W'(g))
            row_q[g] <= row_q[g] & wdata;
      end
      assign fuses[g*DATA_W +: DATA_W] = row_q[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         modes <= '1;
      else if (erase)
         modes <= '1;
      else if (mode_we)
         modes <= modes & wdata[MODE_BITS-1:0];
   end

   always_comb begin
      rd_fuse = '0;
      for (int r = 0; r < ROWS; r++)
         if (addr == ADDR_W'(r)) rd_fuse = rd_fuse | row_q[r];
   end

   if (MODE_BITS == DATA_W) begin : g_mode_full
      assign rd_mode = modes;
   end else begin : g_mode_part
      assign rd_mode = {{(DATA_W-MODE_BITS){1'b0}}, modes};
   end

endmodule

// File: rtl/cfg_sig_reg.sv
module cfg_sig_reg #(
   parameter int SIG_W  = 24,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_word
);

   localparam int SIG_WORDS = (SIG_W + DATA_W - 1) / DATA_W;

   logic [DATA_W-1:0] word_ext [SIG_WORDS];

   for (genvar g = 0; g < SIG_WORDS; g++) begin : g_word
      localparam int LOW  = g * DATA_W;
      localparam int BITS = (SIG_W - LOW) < DATA_W ? (SIG_W - LOW) : DATA_W;
      logic [BITS-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (erase)
            word_q <= '0;
         else if (we && addr == ADDR_W'(g))
            word_q <= wdata[BITS-1:0];
      end

      if (BITS == DATA_W) begin : g_full
         assign word_ext[g] = word_q;
      end else begin : g_part
         assign word_ext[g] = {{(DATA_W-BITS){1'b0}}, word_q};
      end
   end

   always_comb begin
      rd_word = '0;
      for (int w = 0; w < SIG_WORDS; w++)
         if (addr == ADDR_W'(w)) rd_word = rd_word | word_ext[w];
   end

endmodule

// File: rtl/cfg_store_lock.sv
module cfg_store_lock
   import cfg_store_pkg::*;
#(
   parameter int ROWS       = 8,
   parameter int DATA_W     = 16,
   parameter int MACROCELLS = 4,
   parameter int MODE_W     = 2,
   parameter int SIG_W      = 24,
   parameter int ADDR_W     = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [2:0]                   cmd_op,
   input  logic [ADDR_W-1:0]            cmd_addr,
   input  logic [DATA_W-1:0]            cmd_wdata,
   input  logic                         cmd_seal,
   output logic                         rsp_done,
   output logic                         rsp_err,
   output logic [DATA_W-1:0]            rsp_rdata,
   output logic                         sec_locked,
   output logic [ROWS*DATA_W-1:0]       cfg_fuses,
   output logic [MACROCELLS*MODE_W-1:0] cfg_modes
);

   localparam int MODE_BITS = MACROCELLS * MODE_W;
   localparam int SIG_WORDS = (SIG_W + DATA_W - 1) / DATA_W;

   initial begin
      assert (SIG_W == 24 || SIG_W == 64)
         else $error("cfg_store_lock: SIG_W must be 24 or 64");
      assert (MODE_BITS >= 1 && MODE_BITS <= DATA_W)
         else $error("cfg_store_lock: mode word must fit one data word");
      assert ((1 << ADDR_W) > ROWS + 1 && (1 << ADDR_W) > SIG_WORDS)
         else $error("cfg_store_lock: ADDR_W too narrow");
   end

   cfg_ctl_t          ctl;
   logic [DATA_W-1:0] fuse_rd, mode_rd, sig_rd;
   logic [DATA_W-1:0] rdata_d;

   cfg_cmd_decode #(
      .ROWS(ROWS), .SIG_WORDS(SIG_WORDS), .ADDR_W(ADDR_W)
   ) u_dec (
      .valid(cmd_valid), .op(cmd_op), .addr(cmd_addr),
      .seal(cmd_seal), .locked(sec_locked), .ctl(ctl)
   );

   cfg_fuse_bank #(
      .ROWS(ROWS), .DATA_W(DATA_W), .MODE_BITS(MODE_BITS), .ADDR_W(ADDR_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .erase(ctl.erase),
      .fuse_we(ctl.fuse_we), .mode_we(ctl.mode_we),
      .addr(cmd_addr), .wdata(cmd_wdata),
      .fuses(cfg_fuses), .modes(cfg_modes),
      .rd_fuse(fuse_rd), .rd_mode(mode_rd)
   );

   cfg_sig_reg #(
      .SIG_W(SIG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_sig (
      .clk(clk), .rst_n(rst_n), .erase(ctl.erase), .we(ctl.sig_we),
      .addr(cmd_addr), .wdata(cmd_wdata), .rd_word(sig_rd)
   );

   always_comb begin
      rdata_d = '0;
      if (ctl.rd_fuse)      rdata_d = fuse_rd;
      else if (ctl.rd_mode) rdata_d = mode_rd;
      else if (ctl.rd_sig)  rdata_d = sig_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_locked <= 1'b0;
         rsp_done   <= 1'b0;
         rsp_err    <= 1'b0;
         rsp_rdata  <= '0;
      end else begin
         if (ctl.erase)         sec_locked <= 1'b0;
         else if (ctl.set_lock) sec_locked <= 1'b1;
         rsp_done  <= ctl.accept;
         rsp_err   <= ctl.refuse;
         rsp_rdata <= rdata_d;
      end
   end

endmodule

// File: rtl/cfg_store_lock_chk.sv
module cfg_store_lock_chk #(
   parameter int ROWS      = 8,
   parameter int DATA_W    = 16,
   parameter int MODE_BITS = 8,
   parameter int ADDR_W    = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cmd_valid,
   input logic [2:0]              cmd_op,
   input logic [ADDR_W-1:0]       cmd_addr,
   input logic                    cmd_seal,
   input logic                    rsp_done,
   input logic                    rsp_err,
   input logic [DATA_W-1:0]       rsp_rdata,
   input logic                    sec_locked,
   input logic [ROWS*DATA_W-1:0]  cfg_fuses,
   input logic [MODE_BITS-1:0]    cfg_modes
);

   logic is_erase;
   assign is_erase = cmd_valid && cmd_op == 3'd1;

   assert_one_response_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> $countones({rsp_done, rsp_err}) == 1)
      else $error("R11: command without exactly one response");

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_done && !rsp_err)
      else $error("R11: response without command");

   assert_erase_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      is_erase |=> !sec_locked && rsp_done && (&cfg_fuses) && (&cfg_modes))
      else $error("R2: erase did not restore erased state");

   assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sec_locked && !is_erase |=> sec_locked)
      else $error("R5: lock released without erase");

   assert_frozen_when_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sec_locked && !is_erase |=> $stable(cfg_fuses) && $stable(cfg_modes))
      else $error("R7: stored pattern changed while locked");

   assert_only_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !is_erase |=> ((cfg_fuses & ~$past(cfg_fuses)) == '0) &&
                    ((cfg_modes & ~$past(cfg_modes)) == '0))
      else $error("R3: a bit went from 0 to 1 without erase");

   assert_seal_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd2 && cmd_seal && !sec_locked &&
      cmd_addr <= ADDR_W'(ROWS) |=> sec_locked && rsp_done)
      else $error("R6: sealed program did not lock");

   assert_rdata_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_done |-> rsp_rdata == '0)
      else $error("R12: read data outside a completion");

endmodule

bind cfg_store_lock cfg_store_lock_chk #(
   .ROWS(ROWS), .DATA_W(DATA_W), .MODE_BITS(MACROCELLS*MODE_W), .ADDR_W(ADDR_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_addr(cmd_addr), .cmd_seal(cmd_seal), .rsp_done(rsp_done),
   .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .sec_locked(sec_locked),
   .cfg_fuses(cfg_fuses), .cfg_modes(cfg_modes)
);

// File: tb/cfg_store_lock_tb_top.sv
module cfg_store_lock_tb_top;

   localparam int ROWS = 4, DATA_W = 16, MCELLS = 5, MODE_W = 2, SIG_W = 24, ADDR_W = 4;
   localparam int NV = 25;

   typedef struct packed {
      logic [2:0]  op;
      logic [3:0]  addr;
      logic [15:0] data;
      logic        seal;
      logic        e_done;
      logic        e_err;
      logic [15:0] e_rd;
      logic        e_lock;
      logic [3:0]  req;
   } vec_t;

   // op: 1 erase, 2 program, 3 verify, 4 lock, 5 sig write, 6 sig read
   localparam vec_t VECS [NV] = '{
      '{3'd3, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'hFFFF, 1'b0, 4'd1},  // R1 erased row
      '{3'd2, 4'd0, 16'hA5F0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd12}, // R12 no data on program
      '{3'd3, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'hA5F0, 1'b0, 4'd4},  // R4
      '{3'd2, 4'd0, 16'hFF0F, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd3},  // R3 reprogram w/o erase
      '{3'd3, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'hA500, 1'b0, 4'd3},  // R3 AND result
      '{3'd2, 4'd4, 16'hFD55, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd3},  // R3 mode word
      '{3'd3, 4'd4, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0155, 1'b0, 4'd4},  // R4 mode zero-extended
      '{3'd2, 4'd5, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 4'd10}, // R10
      '{3'd5, 4'd0, 16'h1234, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd9},  // R9
      '{3'd5, 4'd1, 16'hABCD, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd9},  // R9
      '{3'd6, 4'd1, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h00CD, 1'b0, 4'd9},  // R9 partial word
      '{3'd5, 4'd2, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 4'd10}, // R10 sig range
      '{3'd7, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 4'd11}, // R11 reserved op
      '{3'd4, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 4'd5},  // R5
      '{3'd3, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 4'd7},  // R7 verify refused
      '{3'd2, 4'd1, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 4'd7},  // R7 program refused
      '{3'd5, 4'd0, 16'hFFFF, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 4'd7},  // R7 sig write refused
      '{3'd6, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h1234, 1'b1, 4'd8},  // R8
      '{3'd1, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd2},  // R2
      '{3'd3, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'hFFFF, 1'b0, 4'd2},  // R2
      '{3'd6, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd2},  // R2 sig cleared
      '{3'd2, 4'd2, 16'h0F0F, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 4'd6},  // R6
      '{3'd3, 4'd2, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 4'd6},  // R6
      '{3'd1, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd2},  // R2 erase while locked
      '{3'd3, 4'd2, 16'h0000, 1'b0, 1'b1, 1'b0, 16'hFFFF, 1'b0, 4'd2}   // R2
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [DATA_W-1:0] cmd_wdata = '0;
   logic cmd_seal = 1'b0;
   logic rsp_done, rsp_err, sec_locked;
   logic [DATA_W-1:0] rsp_rdata;
   logic [ROWS*DATA_W-1:0] cfg_fuses;
   logic [MCELLS*MODE_W-1:0] cfg_modes;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   cfg_store_lock #(
      .ROWS(ROWS), .DATA_W(DATA_W), .MACROCELLS(MCELLS),
      .MODE_W(MODE_W), .SIG_W(SIG_W), .ADDR_W(ADDR_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_seal(cmd_seal),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .sec_locked(sec_locked), .cfg_fuses(cfg_fuses), .cfg_modes(cfg_modes)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [3:0] addr,
                        input logic [15:0] data, input logic seal);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
      cmd_wdata = data; cmd_seal = seal;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = '0; cmd_seal = 1'b0;
   endtask

   task automatic check_reset_state(input string tag);
      chk(tag, "rsp_done", 64'(rsp_done), 64'd0);
      chk(tag, "rsp_err", 64'(rsp_err), 64'd0);
      chk(tag, "rsp_rdata", 64'(rsp_rdata), 64'd0);
      chk(tag, "sec_locked", 64'(sec_locked), 64'd0);
      chk(tag, "cfg_fuses", cfg_fuses, {64{1'b1}});
      chk(tag, "cfg_modes", 64'(cfg_modes), 64'h3FF);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_reset_state("R1");
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         issue(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].seal);
         chk(tag, "rsp_done", 64'(rsp_done), 64'(VECS[i].e_done));
         chk(tag, "rsp_err", 64'(rsp_err), 64'(VECS[i].e_err));
         chk(tag, "rsp_rdata", 64'(rsp_rdata), 64'(VECS[i].e_rd));
         chk(tag, "sec_locked", 64'(sec_locked), 64'(VECS[i].e_lock));
      end

      // R3 / R7: refused program leaves the pattern at the ports untouched
      issue(3'd2, 4'd0, 16'h00FF, 1'b0);
      chk("R3", "fuses after program", cfg_fuses, 64'hFFFF_FFFF_FFFF_00FF);
      issue(3'd4, 4'd0, 16'h0000, 1'b0);
      issue(3'd2, 4'd1, 16'h0000, 1'b0);
      chk("R7", "err on locked program", 64'(rsp_err), 64'd1);
      chk("R7", "fuses unchanged", cfg_fuses, 64'hFFFF_FFFF_FFFF_00FF);
      issue(3'd2, 4'd4, 16'h0000, 1'b0);
      chk("R7", "modes unchanged", 64'(cfg_modes), 64'h3FF);

      // R11 / R12: quiet cycle after a command
      idle();
      @(posedge clk);
      #1;
      chk("R11", "done idle", 64'(rsp_done), 64'd0);
      chk("R11", "err idle", 64'(rsp_err), 64'd0);
      chk("R12", "rdata idle", 64'(rsp_rdata), 64'd0);

      // R1: reset from a locked, programmed state
      issue(3'd1, 4'd0, 16'h0, 1'b0);
      issue(3'd5, 4'd0, 16'h5A5A, 1'b0);
      issue(3'd4, 4'd0, 16'h0, 1'b0);
      idle();
      rst_n = 1'b0;
      #1;
      check_reset_state("R1");
      @(negedge clk);
      rst_n = 1'b1;
      issue(3'd6, 4'd0, 16'h0, 1'b0);
      chk("R1", "signature after reset", 64'(rsp_rdata), 64'd0);
      idle();

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule